// File: doc/BRIEF.md
# Three-Wire Link Host Packet Receiver

This block is the host side of a three-wire serial link (a peripheral-owned clock line, a bidirectional data line and a host-owned acknowledge line) in the peripheral-to-host direction. After a start command it waits for the peripheral to pull its clock line low. It accepts the request, then decides from the data line whether the peripheral commits or abandons the transfer. It collects a header byte and the payload two bits per full handshake, least significant bit first. The header says how many bytes follow. A parity bit and a stop bit close the packet.

Received bytes leave on a byte stream with valid and last flags as soon as each one is complete. A retry controller wraps the single-attempt receiver. When an attempt fails, it asks an external agent to flush the link, waits for that agent to finish, and tries again, up to a fixed number of attempts. One done pulse ends the command. It carries the header length field and error flags for abort, bad header format, parity and framing, or an idle indication when the peripheral never started.

Top module: `tw_host_rx`

## Requirements
- R1: In reset and after it, the acknowledge output is high, no byte valid and no done pulse appear, and the data-line output enable stays 0 at all times.
- R2: After a start command, a low level on the link clock makes the host drive acknowledge low within a few cycles. If the clock stays high for START_TIMEOUT cycles, the command ends with idle=1, no error flags and no flush request.
- R3: On the first rising link clock after the request, data low commits the transfer and data high sets the abort error. In both cases acknowledge returns high.
- R4: Each bit pair is taken as follows. The even bit is sampled when the link clock goes low, and acknowledge then goes low. The odd bit is sampled when the clock goes high, and acknowledge then goes high. Bits of a byte arrive least significant first.
- R5: The first byte is a header. If its bit 3 is 0, the attempt ends right after the header with the format error, and the header is not emitted. Otherwise its bits 2:0 give N, the packet holds N+1 bytes, and len_o reports N.
- R6: Every accepted byte, header included, is emitted once with byte_valid_o. byte_last_o marks the final emitted byte of the attempt.
- R7: Bytes at index MAX_BYTES or above are still handshaken and counted in parity, but they are not emitted. The byte at index MAX_BYTES-1 then carries last.
- R8: When the link clock falls after the last byte, the sampled bit must equal the XOR of all received data bits. A mismatch sets the parity error.
- R9: When the link clock next rises, data must be 1. Data 0 sets the framing error. Acknowledge returns high in either case.
- R10: A failed attempt (abort, format, parity or framing) raises flush_req_o and holds it until flush_done_i, then retries. After RETRY_MAX attempts the command ends with the last attempt's flags. A successful attempt ends it with no flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a receive command (ignored while busy) |
| line_clk_i | input | 1 | Link clock driven by the peripheral (asynchronous) |
| line_data_i | input | 1 | Link data as seen by the host (asynchronous) |
| line_ack_o | output | 1 | Host acknowledge line |
| line_data_oe_o | output | 1 | Host data driver enable, held released |
| flush_req_o | output | 1 | Request for an external link flush between attempts |
| flush_done_i | input | 1 | External flush finished |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | byte_o holds a new byte this cycle |
| byte_last_o | output | 1 | Final emitted byte of the attempt |
| done_o | output | 1 | One-cycle pulse ending the command |
| idle_o | output | 1 | Command ended because no transfer started |
| len_o | output | 3 | Header length field of the final attempt |
| err_abort_o | output | 1 | Peripheral abandoned the request |
| err_format_o | output | 1 | Header bit 3 was clear |
| err_parity_o | output | 1 | Parity bit mismatch |
| err_frame_o | output | 1 | Stop bit was 0 |

## Verification
On every cycle the embedded properties check the handshake discipline. Acknowledge may fall only while the synchronized link clock is low and rise only while it is high. They also check that last never appears without valid, that an idle result never carries an error flag, and that a flush request begins only after an attempt has completed, while the core sits idle. The bench scenarios alone can show the byte values and their bit order, the header-driven packet length, the capacity cut-off whose discarded bytes still count in parity, the error flags for each fault, the retry count seen through flush requests, and the timeout to idle.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;

    localparam int BYTE_W  = 8;
    localparam int PAIRS   = BYTE_W / 2;
    localparam int LEN_W   = 3;
    localparam int FMT_BIT = 3;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_WAIT,
        RX_REQ,
        RX_EVEN,
        RX_ODD,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        TOP_IDLE,
        TOP_RUN,
        TOP_FLUSH
    } top_state_e;

    typedef struct packed {
        logic idle;
        logic abort;
        logic format;
        logic parity;
        logic frame;
    } rx_result_t;

    function automatic logic has_error(rx_result_t r);
        return r.abort | r.format | r.parity | r.frame;
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Lines rest high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tw_rx_core.sv
module tw_rx_core
    import tw_rx_pkg::*;
#(
    parameter int MAX_BYTES     = 4,
    parameter int START_TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              lclk_i,
    input  logic              ldata_i,
    output logic              ack_o,
    output logic              busy_o,
    output logic              done_o,
    output rx_result_t        result_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              byte_last_o
);
    localparam int IW = LEN_W + 1;
    localparam int TW = $clog2(START_TIMEOUT + 1);
    localparam int PW = $clog2(PAIRS);
    localparam logic [IW-1:0] CAP_LAST = IW'(MAX_BYTES - 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(START_TIMEOUT - 1);
    localparam logic [PW-1:0] PAIR_END = PW'(PAIRS - 1);

    rx_state_e         state_q;
    logic              ack_q;
    logic [TW-1:0]     tmo_q;
    logic [BYTE_W-1:0] shift_q;
    logic [PW-1:0]     pair_q;
    logic [IW-1:0]     idx_q;
    logic [IW-1:0]     last_q;
    logic              par_q;
    logic [LEN_W-1:0]  len_q;
    rx_result_t        res_q;
    logic              done_q;
    logic              bv_q;
    logic              bl_q;
    logic [BYTE_W-1:0] byte_q;

    logic [BYTE_W-1:0] nb;
    logic              byte_end;
    logic              is_hdr;
    logic [IW-1:0]     end_idx;
    logic              keep;

    always_comb begin
        nb       = {ldata_i, shift_q[BYTE_W-1:1]};
        byte_end = (pair_q == PAIR_END);
        is_hdr   = (idx_q == '0);
        end_idx  = is_hdr ? IW'(nb[LEN_W-1:0]) : last_q;
        keep     = (idx_q <= CAP_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            ack_q   <= 1'b1;
            tmo_q   <= '0;
            shift_q <= '0;
            pair_q  <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            par_q   <= 1'b0;
            len_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
            bv_q    <= 1'b0;
            bl_q    <= 1'b0;
            byte_q  <= '0;
        end else begin
            done_q <= 1'b0;
            bv_q   <= 1'b0;
            bl_q   <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (start_i) begin
                        state_q <= RX_WAIT;
                        tmo_q   <= '0;
                        res_q   <= '0;
                        len_q   <= '0;
                    end
                end
                RX_WAIT: begin
                    if (!lclk_i) begin
                        ack_q   <= 1'b0;
                        state_q <= RX_REQ;
                    end else if (tmo_q == TMO_LAST) begin
                        res_q.idle <= 1'b1;
                        done_q     <= 1'b1;
                        state_q    <= RX_IDLE;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
                RX_REQ: begin
                    if (lclk_i) begin
                        ack_q <= 1'b1;
                        if (ldata_i) begin
                            res_q.abort <= 1'b1;
                            done_q      <= 1'b1;
                            state_q     <= RX_IDLE;
                        end else begin
                            state_q <= RX_EVEN;
                            pair_q  <= '0;
                            idx_q   <= '0;
                            par_q   <= 1'b0;
                        end
                    end
                end
                RX_EVEN: begin
                    if (!lclk_i) begin
                        ack_q   <= 1'b0;
                        shift_q <= nb;
                        par_q   <= par_q ^ ldata_i;
                        state_q <= RX_ODD;
                    end
                end
                RX_ODD: begin
                    if (lclk_i) begin
                        ack_q   <= 1'b1;
                        shift_q <= nb;
                        par_q   <= par_q ^ ldata_i;
                        pair_q  <= pair_q + 1'b1;
                        state_q <= RX_EVEN;
                        if (byte_end) begin
                            if (is_hdr && !nb[FMT_BIT]) begin
                                res_q.format <= 1'b1;
                                done_q       <= 1'b1;
                                state_q      <= RX_IDLE;
                            end else begin
                                if (is_hdr) begin
                                    len_q  <= nb[LEN_W-1:0];
                                    last_q <= end_idx;
                                end
                                if (keep) begin
                                    bv_q   <= 1'b1;
                                    byte_q <= nb;
                                    bl_q   <= (idx_q == end_idx) || (idx_q == CAP_LAST);
                                end
                                if (idx_q == end_idx) begin
                                    state_q <= RX_PAR;
                                end else begin
                                    idx_q <= idx_q + 1'b1;
                                end
                            end
                        end
                    end
                end
                RX_PAR: begin
                    if (!lclk_i) begin
                        ack_q        <= 1'b0;
                        res_q.parity <= (ldata_i != par_q);
                        state_q      <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (lclk_i) begin
                        ack_q       <= 1'b1;
                        res_q.frame <= !ldata_i;
                        done_q      <= 1'b1;
                        state_q     <= RX_IDLE;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign ack_o        = ack_q;
    assign busy_o       = (state_q != RX_IDLE);
    assign done_o       = done_q;
    assign result_o     = res_q;
    assign len_o        = len_q;
    assign byte_o       = byte_q;
    assign byte_valid_o = bv_q;
    assign byte_last_o  = bl_q;

    assert_ack_fall_clk_low_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_q) |-> !$past(lclk_i));

    assert_ack_rise_clk_high_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(lclk_i));

    assert_last_has_valid_R6: assert property (@(posedge clk) disable iff (rst)
        bl_q |-> bv_q);

    assert_idle_no_error_R2: assert property (@(posedge clk) disable iff (rst)
        (done_q && res_q.idle) |-> !has_error(res_q));

endmodule

// File: rtl/tw_host_rx.sv
module tw_host_rx
    import tw_rx_pkg::*;
#(
    parameter int MAX_BYTES     = 4,
    parameter int START_TIMEOUT = 256,
    parameter int RETRY_MAX     = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              line_clk_i,
    input  logic              line_data_i,
    output logic              line_ack_o,
    output logic              line_data_oe_o,
    output logic              flush_req_o,
    input  logic              flush_done_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              byte_last_o,
    output logic              done_o,
    output logic              idle_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              err_abort_o,
    output logic              err_format_o,
    output logic              err_parity_o,
    output logic              err_frame_o
);
    localparam int AW = $clog2(RETRY_MAX + 1);
    localparam logic [AW-1:0] ATT_MAX = AW'(RETRY_MAX);

    logic [1:0]       line_s;
    logic             core_start_q;
    logic             core_busy;
    logic             core_done;
    rx_result_t       core_res;
    logic [LEN_W-1:0] core_len;

    top_state_e       st_q;
    logic [AW-1:0]    att_q;
    logic             flush_q;
    logic             done_q;
    rx_result_t       fin_q;
    logic [LEN_W-1:0] flen_q;

    tw_line_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({line_clk_i, line_data_i}),
        .q_o (line_s)
    );

    tw_rx_core #(
        .MAX_BYTES     (MAX_BYTES),
        .START_TIMEOUT (START_TIMEOUT)
    ) u_core (
        .clk          (clk),
        .rst          (rst),
        .start_i      (core_start_q),
        .lclk_i       (line_s[1]),
        .ldata_i      (line_s[0]),
        .ack_o        (line_ack_o),
        .busy_o       (core_busy),
        .done_o       (core_done),
        .result_o     (core_res),
        .len_o        (core_len),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .byte_last_o  (byte_last_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= TOP_IDLE;
            core_start_q <= 1'b0;
            att_q        <= '0;
            flush_q      <= 1'b0;
            done_q       <= 1'b0;
            fin_q        <= '0;
            flen_q       <= '0;
        end else begin
            core_start_q <= 1'b0;
            done_q       <= 1'b0;
            unique case (st_q)
                TOP_IDLE: begin
                    if (start_i) begin
                        core_start_q <= 1'b1;
                        att_q        <= AW'(1);
                        fin_q        <= '0;
                        flen_q       <= '0;
                        st_q         <= TOP_RUN;
                    end
                end
                TOP_RUN: begin
                    if (core_done) begin
                        if (core_res.idle || !has_error(core_res) || att_q == ATT_MAX) begin
                            fin_q  <= core_res;
                            flen_q <= core_len;
                            done_q <= 1'b1;
                            st_q   <= TOP_IDLE;
                        end else begin
                            flush_q <= 1'b1;
                            st_q    <= TOP_FLUSH;
                        end
                    end
                end
                TOP_FLUSH: begin
                    if (flush_done_i) begin
                        flush_q      <= 1'b0;
                        core_start_q <= 1'b1;
                        att_q        <= att_q + 1'b1;
                        st_q         <= TOP_RUN;
                    end
                end
                default: st_q <= TOP_IDLE;
            endcase
        end
    end

    assign line_data_oe_o = 1'b0;
    assign flush_req_o    = flush_q;
    assign done_o         = done_q;
    assign idle_o         = fin_q.idle;
    assign len_o          = flen_q;
    assign err_abort_o    = fin_q.abort;
    assign err_format_o   = fin_q.format;
    assign err_parity_o   = fin_q.parity;
    assign err_frame_o    = fin_q.frame;

    assert_flush_core_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> !core_busy);

    assert_flush_after_attempt_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_q) |-> $past(core_done));

endmodule

// File: tb/tw_host_rx_tb.sv
module tw_host_rx_tb;
    localparam int CAP = 4;
    localparam int TMO = 64;

    logic clk = 1'b0;
    logic rst, start, ln_clk, ln_data, flush_done;
    logic ack, data_oe, flush_req, byte_valid, byte_last, done;
    logic idle, e_abort, e_format, e_parity, e_frame;
    logic [7:0] byte_val;
    logic [2:0] len;

    int checks = 0;
    int fails = 0;
    int flush_cnt = 0;
    int req_lat = 0;
    bit oe_seen = 1'b0;

    typedef struct packed {
        logic [7:0] b;
        logic       last;
    } exp_t;
    exp_t exp_q[$];
    exp_t mon_e;

    always #10 clk = ~clk;

    tw_host_rx #(
        .MAX_BYTES     (CAP),
        .START_TIMEOUT (TMO),
        .RETRY_MAX     (8),
        .SYNC_STAGES   (2)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .line_clk_i     (ln_clk),
        .line_data_i    (ln_data),
        .line_ack_o     (ack),
        .line_data_oe_o (data_oe),
        .flush_req_o    (flush_req),
        .flush_done_i   (flush_done),
        .byte_o         (byte_val),
        .byte_valid_o   (byte_valid),
        .byte_last_o    (byte_last),
        .done_o         (done),
        .idle_o         (idle),
        .len_o          (len),
        .err_abort_o    (e_abort),
        .err_format_o   (e_format),
        .err_parity_o   (e_parity),
        .err_frame_o    (e_frame)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each emitted byte with the queue head.
    always @(negedge clk) begin
        if (data_oe === 1'b1) oe_seen = 1'b1;
        if (!rst && byte_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected byte", {24'd0, byte_val}, 32'd0);
            end else begin
                mon_e = exp_q.pop_front();
                chk(byte_val == mon_e.b, "R4/R6 byte value", {24'd0, byte_val}, {24'd0, mon_e.b});
                chk(byte_last == mon_e.last, "R6/R7 last flag", {31'd0, byte_last}, {31'd0, mon_e.last});
            end
        end
    end

    // External flush agent.
    initial begin
        flush_done = 1'b0;
        forever begin
            @(negedge clk);
            if (flush_req === 1'b1) begin
                repeat (3) @(negedge clk);
                flush_done = 1'b1;
                @(negedge clk);
                flush_done = 1'b0;
                flush_cnt++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    task automatic wait_ack(input logic v);
        while (ack !== v) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    // Peripheral model for one attempt; pushes the bytes the host should emit.
    task automatic send_attempt(input logic [63:0] pk, input int nb, input bit abort,
                                input bit flip_par, input bit bad_stop);
        logic par;
        par = 1'b0;
        ln_data = 1'b1;
        @(negedge clk);
        ln_clk = 1'b0;
        req_lat = 0;
        while (ack !== 1'b0) begin
            @(negedge clk);
            req_lat++;
        end
        ln_data = abort ? 1'b1 : 1'b0;
        repeat (2) @(negedge clk);
        ln_clk = 1'b1;
        wait_ack(1'b1);
        ln_data = 1'b1;
        if (abort) return;
        for (int i = 0; i < nb; i++) begin
            if (!(i == 0 && !pk[3]) && i < CAP)
                exp_q.push_back({pk[8*i +: 8], (i == nb - 1) || (i == CAP - 1)});
        end
        for (int i = 0; i < nb; i++) begin
            for (int p = 0; p < 4; p++) begin
                ln_data = pk[8*i + 2*p];
                par = par ^ ln_data;
                repeat (2) @(negedge clk);
                ln_clk = 1'b0;
                wait_ack(1'b0);
                ln_data = pk[8*i + 2*p + 1];
                par = par ^ ln_data;
                repeat (2) @(negedge clk);
                ln_clk = 1'b1;
                wait_ack(1'b1);
            end
        end
        if (pk[3]) begin
            ln_data = par ^ flip_par;
            repeat (2) @(negedge clk);
            ln_clk = 1'b0;
            wait_ack(1'b0);
            ln_data = !bad_stop;
            repeat (2) @(negedge clk);
            ln_clk = 1'b1;
            wait_ack(1'b1);
        end
        ln_data = 1'b1;
    endtask

    task automatic fail_series(input logic [63:0] pk, input int nb, input bit abort,
                               input bit flip_par, input bit bad_stop);
        int base;
        base = flush_cnt;
        pulse_start();
        for (int k = 0; k < 8; k++) begin
            send_attempt(pk, nb, abort, flip_par, bad_stop);
            if (k < 7) begin
                while (flush_cnt != base + k + 1) @(negedge clk);
                repeat (2) @(negedge clk);
            end
        end
        wait_done();
        chk(flush_cnt - base == 7, "R10 flush count after 8 failures", flush_cnt - base, 7);
    endtask

    initial begin
        int base;
        int t0;
        rst = 1'b1;
        start = 1'b0;
        ln_clk = 1'b1;
        ln_data = 1'b1;
        repeat (5) @(negedge clk);
        chk(ack == 1'b1, "R1 ack in reset", {31'd0, ack}, 1);
        chk(byte_valid == 1'b0 && done == 1'b0, "R1 outputs quiet in reset", {30'd0, byte_valid, done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(ack == 1'b1, "R1 ack after reset", {31'd0, ack}, 1);

        // Idle: no start from the peripheral.
        base = flush_cnt;
        pulse_start();
        t0 = 0;
        while (done !== 1'b1) begin
            @(negedge clk);
            t0++;
        end
        chk(idle == 1'b1, "R2 idle flag", {31'd0, idle}, 1);
        chk({e_abort, e_format, e_parity, e_frame} == 4'b0, "R2 idle has no errors",
            {28'd0, e_abort, e_format, e_parity, e_frame}, 0);
        chk(t0 >= TMO && t0 <= TMO + 10, "R2 idle timeout length", t0, TMO);
        chk(flush_cnt == base, "R2 no flush on idle", flush_cnt, base);

        // Good packet, header N=2.
        pulse_start();
        send_attempt(64'h0000_0000_00A3_5C0A, 3, 1'b0, 1'b0, 1'b0);
        wait_done();
        chk(req_lat <= 5, "R2 request acknowledged promptly", req_lat, 5);
        chk({idle, e_abort, e_format, e_parity, e_frame} == 5'b0, "R8/R9 good packet flags",
            {27'd0, idle, e_abort, e_format, e_parity, e_frame}, 0);
        chk(len == 3'd2, "R5 length field", {29'd0, len}, 2);

        // Capacity: N=7, only 4 bytes emitted, parity over all 8.
        pulse_start();
        send_attempt(64'h0766_5544_3322_110F, 8, 1'b0, 1'b0, 1'b0);
        wait_done();
        chk(e_parity == 1'b0, "R7 parity covers discarded bytes", {31'd0, e_parity}, 0);
        chk(len == 3'd7, "R5/R7 length field", {29'd0, len}, 7);

        // Abort on every attempt.
        fail_series(64'h0, 1, 1'b1, 1'b0, 1'b0);
        chk(e_abort == 1'b1, "R3 abort flag", {31'd0, e_abort}, 1);

        // One abort then success.
        base = flush_cnt;
        pulse_start();
        send_attempt(64'h0, 1, 1'b1, 1'b0, 1'b0);
        while (flush_cnt != base + 1) @(negedge clk);
        repeat (2) @(negedge clk);
        send_attempt(64'h0000_0000_0000_7708, 1, 1'b0, 1'b0, 1'b0);
        wait_done();
        chk(e_abort == 1'b0 && idle == 1'b0, "R10 retry recovers", {30'd0, e_abort, idle}, 0);
        chk(flush_cnt - base == 1, "R10 one flush before recovery", flush_cnt - base, 1);
        chk(len == 3'd0, "R5 single-byte packet length", {29'd0, len}, 0);

        // Bad header format.
        fail_series(64'h0000_0000_0000_0002, 1, 1'b0, 1'b0, 1'b0);
        chk(e_format == 1'b1, "R5 format flag", {31'd0, e_format}, 1);

        // Wrong parity.
        fail_series(64'h0000_0000_0000_3309, 2, 1'b0, 1'b1, 1'b0);
        chk(e_parity == 1'b1 && e_frame == 1'b0, "R8 parity flag", {30'd0, e_parity, e_frame}, 2);

        // Bad stop bit.
        fail_series(64'h0000_0000_0000_0008, 1, 1'b0, 1'b0, 1'b1);
        chk(e_frame == 1'b1 && e_parity == 1'b0, "R9 framing flag", {30'd0, e_frame, e_parity}, 2);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected bytes emitted", exp_q.size(), 0);
        chk(oe_seen == 1'b0, "R1 data driver stays released", {31'd0, oe_seen}, 0);
        chk(ack == 1'b1, "R9 ack high at rest", {31'd0, ack}, 1);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule